// File: doc/BRIEF.md
# Match-Action Timer Counter with PWM

A timer counter that advances on a count-enable strobe from an upstream input unit. The strobe first passes through a programmable prescaler. Each of the four comparators watches the counter. When a comparator's value is reached, its own selection of actions fires: return the counter to zero, halt counting, raise a sticky flag that feeds a shared interrupt line, and drive its output bit with a two-bit set/clear/toggle control. The output bit starts from a level loaded when the channel is configured.

The counter has a run bit. The run bit is written from outside and is cleared by a stop action. A counter-reset input clears both the counter and the prescaler. Flags are cleared by writing ones to their positions. In PWM mode, comparator 3 is the period register and always wraps the counter. Channels 0 to 2 then output a level that goes high once the counter reaches their duty value. Asking for PWM on channel 3 is refused and reported.

Top module: `match_timer`

## Requirements
- R1: During and right after the active-low synchronous reset, count, running, match_flag, match_out, irq are all 0.
- R2: With prescale value P, the counter increments once per P+1 accepted strobes (P=0: every strobe). A strobe is accepted only while running is 1 and cnt_rst is 0.
- R3: A channel with act_rst set makes the counter go to 0, instead of value+1, on the first increment after the counter equals its match value. The counter therefore cycles through 0..M.
- R4: A channel with act_stop set clears running on the same clock edge at which the counter becomes equal to its match value. The counter then holds that value. A stop wins over a run_wr in the same cycle.
- R5: On a match event, out_ctl of the channel selects the new output level: 0 keeps it, 1 drives 0, 2 drives 1, 3 inverts it. out_ctl of channel i is bits [2i+1:2i].
- R6: A pulse on cfg_load[i] loads out_init[i] into output bit i. The load takes priority over a match action in the same cycle.
- R7: A match event sets match_flag[i] only when act_irq[i] is 1. irq is the OR of all flags.
- R8: Writing 1 to flag_clr[i] clears match_flag[i], and other flags are left alone. A set in the same cycle wins over the clear.
- R9: While cnt_rst is 1, the counter and the prescaler are 0 from the next edge on, and strobes are ignored. Counting resumes from a cleared prescaler after release.
- R10: run_wr with run_val loads the running bit. While running is 0, strobes leave the counter unchanged.
- R11: When pwm_en has any of bits 0..2 set, channel 3 wraps the counter as if act_rst[3] were set. Each PWM channel i then outputs 1 exactly when count >= its match value. A duty value above the period gives constant 0.
- R12: pwm_en[3] sets pwm_err and does not make channel 3 a period register or a PWM output. Channel 3 keeps its normal match behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable strobe |
| run_wr | input | 1 | Write strobe for the running bit |
| run_val | input | 1 | Value written to the running bit |
| cnt_rst | input | 1 | Counter-reset control, level sensitive |
| flag_clr | input | 4 | Write-1-to-clear for match flags |
| prescale | input | 32 | Prescale value P |
| match_val | input | 128 | Four 32-bit match values, channel i at [32i+31:32i] |
| act_rst | input | 4 | Reset-on-match enables |
| act_stop | input | 4 | Stop-on-match enables |
| act_irq | input | 4 | Flag-on-match enables |
| out_ctl | input | 8 | Output action per channel, 2 bits each |
| out_init | input | 4 | Initial output levels |
| cfg_load | input | 4 | Load initial level pulse per channel |
| pwm_en | input | 4 | PWM mode select per channel |
| count | output | 32 | Timer counter value |
| running | output | 1 | Counter-enable state |
| match_flag | output | 4 | Sticky match flags |
| match_out | output | 4 | Match output bits |
| irq | output | 1 | Interrupt request |
| pwm_err | output | 1 | PWM requested on the period channel |

## Verification
The counter is swept over prescale 0 to 3 against wrap values 2, 3 and 5. The strobe pattern has a gap in every fourth cycle, which separates strobe counting from clock counting and also catches an off-by-one in the prescaler or in the wrap point. All four output actions are tried from both initial levels over two successive matches, so that toggle can be told apart from set and clear. Single cases then cover stop, flag set-versus-clear, held counter reset with a half-filled prescaler, and a three-channel PWM run with normal, zero and out-of-period duty values.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
// Shared types for the match-action timer.
package mt_pkg;
    // Output action applied on a match event.
    typedef enum logic [1:0] {
        OC_KEEP = 2'd0,
        OC_LOW  = 2'd1,
        OC_HIGH = 2'd2,
        OC_FLIP = 2'd3
    } oc_e;
endpackage

// File: rtl/mt_prescale.sv
`timescale 1ns/1ps
// Prescaler: counts accepted strobes and emits a roll pulse when the
// count reaches the limit, then restarts from zero.
// Assumes step is already gated by run state and counter reset.
module mt_prescale #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [PRE_W-1:0] limit,
    output logic             roll
);
    logic [PRE_W-1:0] pc_q;
    logic             at_lim;

    assign at_lim = (pc_q >= limit);
    assign roll   = step & at_lim;

    // Advance or clear the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pc_q <= '0;
        else if (step)      pc_q <= at_lim ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/mt_counter.sv
`timescale 1ns/1ps
// Timer counter register with wrap-to-zero on a reset-enabled match.
// Exposes the value it would load so comparators can detect the new value.
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             wrap,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] nxt
);
    logic [CNT_W-1:0] tc_q;

    assign nxt   = wrap ? '0 : tc_q + 1'b1;
    assign value = tc_q;

    // Hold, clear or step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tc_q <= '0;
        else if (inc)      tc_q <= nxt;
    end
endmodule

// File: rtl/mt_match_chan.sv
`timescale 1ns/1ps
// One match channel output stage: holds the output bit, applies the
// selected action on a hit, loads the initial level, and in PWM mode
// replaces the bit by a compare of the counter against the duty value.
module mt_match_chan
    import mt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             init_lvl,
    input  oc_e              ctl,
    input  logic             hit,
    input  logic             pwm_mode,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] duty,
    output logic             out
);
    logic em_q;

    // Output bit: initial-level load has priority over a match action.
    always_ff @(posedge clk) begin
        if (!rst_n)   em_q <= 1'b0;
        else if (load) em_q <= init_lvl;
        else if (hit) begin
            case (ctl)
                OC_LOW:  em_q <= 1'b0;
                OC_HIGH: em_q <= 1'b1;
                OC_FLIP: em_q <= ~em_q;
                default: em_q <= em_q;
            endcase
        end
    end

    assign out = pwm_mode ? (tc >= duty) : em_q;
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
// Match-action timer counter with PWM.
// A prescaled counter is compared against NUM_MATCH values. Each hit can
// wrap, stop, flag and drive an output. The last channel acts as the PWM
// period whenever any other channel is in PWM mode.
// Assumes NUM_MATCH >= 2 and control pulses last one clock.
module match_timer
    import mt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PRE_W     = 32,
    parameter int NUM_MATCH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       run_wr,
    input  logic                       run_val,
    input  logic                       cnt_rst,
    input  logic [NUM_MATCH-1:0]       flag_clr,
    input  logic [PRE_W-1:0]           prescale,
    input  logic [NUM_MATCH*CNT_W-1:0] match_val,
    input  logic [NUM_MATCH-1:0]       act_rst,
    input  logic [NUM_MATCH-1:0]       act_stop,
    input  logic [NUM_MATCH-1:0]       act_irq,
    input  logic [2*NUM_MATCH-1:0]     out_ctl,
    input  logic [NUM_MATCH-1:0]       out_init,
    input  logic [NUM_MATCH-1:0]       cfg_load,
    input  logic [NUM_MATCH-1:0]       pwm_en,
    output logic [CNT_W-1:0]           count,
    output logic                       running,
    output logic [NUM_MATCH-1:0]       match_flag,
    output logic [NUM_MATCH-1:0]       match_out,
    output logic                       irq,
    output logic                       pwm_err
);
    localparam int PER_CH = NUM_MATCH - 1;

    logic                 run_q;
    logic                 cnt_go;
    logic                 inc;
    logic                 wrap;
    logic                 pwm_any;
    logic [CNT_W-1:0]     tc;
    logic [CNT_W-1:0]     tc_nxt;
    logic [NUM_MATCH-1:0] at_val;
    logic [NUM_MATCH-1:0] hit;
    logic [NUM_MATCH-1:0] rst_sel;
    logic [NUM_MATCH-1:0] flag_q;

    assign cnt_go  = tick & run_q & ~cnt_rst;
    assign pwm_any = |pwm_en[PER_CH-1:0];

    // Channels that wrap the counter: user selection plus PWM period.
    always_comb begin
        rst_sel = act_rst;
        if (pwm_any) rst_sel[PER_CH] = 1'b1;
    end

    assign wrap = |(rst_sel & at_val);

    mt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_rst),
        .step  (cnt_go),
        .limit (prescale),
        .roll  (inc)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_rst),
        .inc   (inc),
        .wrap  (wrap),
        .value (tc),
        .nxt   (tc_nxt)
    );

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_ch
        logic [CNT_W-1:0] mval;
        logic             pwm_i;
        assign mval      = match_val[i*CNT_W +: CNT_W];
        assign at_val[i] = (tc == mval);
        assign hit[i]    = inc & (tc_nxt == mval);
        if (i < PER_CH) begin : g_pwm
            assign pwm_i = pwm_en[i];
        end else begin : g_per
            assign pwm_i = 1'b0;
        end
        mt_match_chan #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_load[i]),
            .init_lvl (out_init[i]),
            .ctl      (oc_e'(out_ctl[2*i +: 2])),
            .hit      (hit[i]),
            .pwm_mode (pwm_i),
            .tc       (tc),
            .duty     (mval),
            .out      (match_out[i])
        );
    end

    // Running bit: a stop-on-match wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= 1'b0;
        else if (|(hit & act_stop))  run_q <= 1'b0;
        else if (run_wr)             run_q <= run_val;
    end

    // Sticky flags: set on enabled hits, cleared by write-1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | (hit & act_irq);
    end

    assign count      = tc;
    assign running    = run_q;
    assign match_flag = flag_q;
    assign irq        = |flag_q;
    assign pwm_err    = pwm_en[PER_CH];
endmodule

// File: rtl/mt_checker.sv
`timescale 1ns/1ps
// Property checker for match_timer, attached by bind.
module mt_checker #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_rst,
    input logic [NUM_MATCH-1:0] flag_clr,
    input logic [NUM_MATCH-1:0] out_init,
    input logic [NUM_MATCH-1:0] cfg_load,
    input logic [NUM_MATCH-1:0] pwm_en,
    input logic [CNT_W-1:0]     count,
    input logic                 running,
    input logic [NUM_MATCH-1:0] match_flag,
    input logic [NUM_MATCH-1:0] match_out,
    input logic                 irq
);
    a_r9_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (count == '0));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_rst) |=> $stable(count));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rst |=> (count == '0 || count == $past(count) ||
                      count == $past(count) + 1'b1));

    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr == '1 && !running) |=> (match_flag == '0));

    a_r7_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(running));

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_init
        a_r6_init_load: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_load[i] |=> (pwm_en[i] || match_out[i] == $past(out_init[i])));
    end
endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_rst    (cnt_rst),
    .flag_clr   (flag_clr),
    .out_init   (out_init),
    .cfg_load   (cfg_load),
    .pwm_en     (pwm_en),
    .count      (count),
    .running    (running),
    .match_flag (match_flag),
    .match_out  (match_out),
    .irq        (irq)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
    logic        clk = 1'b0;
    logic        rst_n, tick, run_wr, run_val, cnt_rst;
    logic [3:0]  flag_clr, act_rst, act_stop, act_irq, out_init, cfg_load, pwm_en;
    logic [31:0] prescale;
    logic [31:0] mv [4];
    logic [1:0]  oc [4];
    logic [127:0] match_val;
    logic [7:0]  out_ctl;
    logic [31:0] count;
    logic        running, irq, pwm_err;
    logic [3:0]  match_flag, match_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    assign match_val = {mv[3], mv[2], mv[1], mv[0]};
    assign out_ctl   = {oc[3], oc[2], oc[1], oc[0]};

    always #5 clk = ~clk;

    match_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_wr(run_wr), .run_val(run_val),
        .cnt_rst(cnt_rst), .flag_clr(flag_clr), .prescale(prescale),
        .match_val(match_val), .act_rst(act_rst), .act_stop(act_stop),
        .act_irq(act_irq), .out_ctl(out_ctl), .out_init(out_init),
        .cfg_load(cfg_load), .pwm_en(pwm_en), .count(count), .running(running),
        .match_flag(match_flag), .match_out(match_out), .irq(irq), .pwm_err(pwm_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs set before, outputs sampled after (negedge).
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic setup();
        tick = 0; prescale = 0; act_rst = 0; act_stop = 0; act_irq = 0;
        out_init = 0; cfg_load = 0; pwm_en = 0;
        for (int i = 0; i < 4; i++) begin mv[i] = 32'hFFFF_FFFF; oc[i] = 2'd0; end
        cnt_rst = 1; flag_clr = 4'hF; run_wr = 1; run_val = 0;
        cyc();
        cnt_rst = 0; flag_clr = 0; run_wr = 0;
    endtask

    task automatic start();
        run_wr = 1; run_val = 1; cyc(); run_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tick = 0; run_wr = 0; run_val = 0; cnt_rst = 0; flag_clr = 0;
        prescale = 0; act_rst = 0; act_stop = 0; act_irq = 0; out_init = 0;
        cfg_load = 0; pwm_en = 0;
        for (int i = 0; i < 4; i++) begin mv[i] = 0; oc[i] = 0; end
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 running", {31'b0, running}, 0);
        chk("R1 flags", {28'b0, match_flag}, 0);
        chk("R1 outs", {28'b0, match_out}, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2/R3 sweep: prescale x wrap value, gapped strobes
        for (int p = 0; p < 4; p++) begin
            for (int mi = 0; mi < 3; mi++) begin
                int m;
                int nt;
                m = (mi == 0) ? 2 : (mi == 1) ? 3 : 5;
                setup();
                prescale = p; mv[0] = m; act_rst[0] = 1; act_irq[0] = 1;
                start();
                nt = 0;
                for (int k = 0; k < 24; k++) begin
                    tick = (k % 4 != 3);
                    cyc();
                    if (k % 4 != 3) nt++;
                    chk("R2 R3 count", count, (nt / (p + 1)) % (m + 1));
                end
                tick = 0;
                chk("R7 flag set", {31'b0, match_flag[0]}, ((nt / (p + 1)) >= m) ? 1 : 0);
                chk("R7 irq", {31'b0, irq}, ((nt / (p + 1)) >= m) ? 1 : 0);
            end
        end

        // R10 halt: strobes ignored while not running
        begin
            logic [31:0] held;
            held = count;
            run_wr = 1; run_val = 0; tick = 1; cyc(); run_wr = 0;
            held = count;
            repeat (5) cyc();
            tick = 0;
            chk("R10 halted count", count, held);
            chk("R10 running", {31'b0, running}, 0);
        end

        // R5/R6 output actions from both initial levels
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 2; v++) begin
                logic e1, e2;
                setup();
                mv[1] = 1; act_rst[1] = 1; oc[1] = c[1:0]; out_init[1] = v[0];
                cfg_load = 4'b0010; cyc(); cfg_load = 0;
                chk("R6 init level", {31'b0, match_out[1]}, v);
                start();
                e1 = (c == 0) ? v[0] : (c == 1) ? 1'b0 : (c == 2) ? 1'b1 : ~v[0];
                e2 = (c == 3) ? v[0] : e1;
                tick = 1; cyc();
                chk("R5 first match", {31'b0, match_out[1]}, {31'b0, e1});
                cyc(); cyc(); tick = 0;
                chk("R5 second match", {31'b0, match_out[1]}, {31'b0, e2});
            end
        end

        // R4 stop on match, flag disabled (R7)
        setup();
        mv[2] = 4; act_stop[2] = 1;
        start();
        for (int k = 0; k < 10; k++) begin
            tick = 1; cyc();
            chk("R4 count", count, (k + 1 < 4) ? k + 1 : 4);
            chk("R4 running", {31'b0, running}, (k + 1 < 4) ? 1 : 0);
        end
        tick = 0;
        chk("R7 no flag when disabled", {28'b0, match_flag}, 0);
        chk("R7 no irq when disabled", {31'b0, irq}, 0);

        // R8 write-1-to-clear, set wins
        setup();
        mv[0] = 1; mv[1] = 1; mv[2] = 2; act_irq = 4'b0111;
        start();
        tick = 1; cyc(); tick = 0;
        chk("R8 flags set", {28'b0, match_flag}, 32'h3);
        tick = 1; flag_clr = 4'b0101; cyc(); tick = 0; flag_clr = 0;
        chk("R8 clear and set", {28'b0, match_flag}, 32'h6);
        flag_clr = 4'b0110; cyc(); flag_clr = 0;
        chk("R8 all cleared", {28'b0, match_flag}, 0);
        chk("R8 irq low", {31'b0, irq}, 0);

        // R9 counter reset clears both counters, held
        setup();
        prescale = 2;
        start();
        tick = 1; repeat (5) cyc();
        chk("R9 pre count", count, 1);
        cnt_rst = 1;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R9 held at zero", count, 0);
        end
        cnt_rst = 0;
        cyc(); cyc();
        chk("R9 prescaler cleared", count, 0);
        cyc(); tick = 0;
        chk("R9 resumes", count, 1);

        // R11 PWM: period 4, duty 2, duty 0, duty above period
        setup();
        mv[0] = 2; mv[1] = 0; mv[2] = 7; mv[3] = 4; pwm_en = 4'b0111;
        start();
        for (int k = 0; k < 15; k++) begin
            int ec;
            tick = 1; cyc();
            ec = (k + 1) % 5;
            chk("R11 count", count, ec);
            chk("R11 duty out", {29'b0, match_out[2:0]}, {29'b0, 1'b0, 1'b1, (ec >= 2) ? 1'b1 : 1'b0});
        end
        tick = 0;

        // R12 PWM on channel 3 rejected
        setup();
        mv[3] = 3; pwm_en = 4'b1000; out_init[3] = 1;
        cfg_load = 4'b1000; cyc(); cfg_load = 0;
        chk("R12 pwm_err", {31'b0, pwm_err}, 1);
        start();
        tick = 1; repeat (5) cyc(); tick = 0;
        chk("R12 no period wrap", count, 5);
        chk("R12 normal output", {31'b0, match_out[3]}, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule